// File: doc/BRIEF.md
# SM4 Round-Function Byte-Step Unit

This block speeds up the SM4 block cipher by evaluating its nonlinear round transform one byte at a time. Each operation takes one byte of an operand word, chosen by a selector, and passes it through the SM4 substitution box. It then spreads the substituted byte across 32 bits with a linear layer and rotates the result into the byte lane the selector names. Finally it XORs that word into an accumulator operand. A mode bit picks one of two linear layers: the one used for data encryption and decryption, or the one used by the key schedule.

The block has two paths. The step path is purely combinational and performs a single byte-step, as a processor execution stage would. The round path is a small sequencer that owns a second byte-step datapath. On a start request it forms the round input from three state words and a round key, then chains four byte-steps over four clock cycles to produce one complete round output. Every result is sign-extended from 32 bits to the configured register width. The number of cycles never depends on the data.

Top module: `sm4_round_unit`

## Requirements
- R1: The step path uses only bits [1:0] of `step_sel` to choose the byte of `step_a`: value 0 selects bits [7:0], 1 selects [15:8], 2 selects [23:16], 3 selects [31:24]. Setting any higher selector bit does not change `step_y`.
- R2: The chosen byte is replaced by its SM4 S-box value before any linear mixing.
- R3: With mode 0 (cipher), the substituted byte s, zero-extended to 32 bits, becomes c = s ^ rol(s,2) ^ rol(s,10) ^ rol(s,18) ^ rol(s,24).
- R4: With mode 1 (key schedule), the substituted byte becomes c = s ^ rol(s,13) ^ rol(s,23).
- R5: The 32-bit step result is rol(c, 8*sel) XOR the accumulator operand.
- R6: A round computes a = x1^x2^x3^rk. It then applies four byte-steps with selectors 0, 1, 2, 3 in that order: the first uses x0 as the accumulator, and each later step uses the previous result.
- R7: `step_y` and `round_out` carry the 32-bit result sign-extended to XLEN bits.
- R8: A start seen at a rising edge while idle makes `busy` high for exactly the next four cycles. `done` is then high for exactly one cycle, in which `round_out` holds the new result.
- R9: A start asserted while `busy` is high is ignored. The running round keeps its timing and its result.
- R10: After reset `busy` and `done` are low and `round_out` is zero. `round_out` changes only when a round completes.
- R11: The round latency is the same for every data value and every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_x | input | 32 | Step path accumulator operand |
| step_a | input | 32 | Step path byte source operand |
| step_sel | input | SEL_W | Step path byte selector, only bits [1:0] used |
| step_mode | input | 1 | Step path linear layer: 0 cipher, 1 key schedule |
| step_y | output | XLEN | Step path result, sign-extended |
| start | input | 1 | Round request, taken only while idle |
| round_mode | input | 1 | Round linear layer: 0 cipher, 1 key schedule |
| x0 | input | 32 | Round state word 0, initial accumulator |
| x1 | input | 32 | Round state word 1 |
| x2 | input | 32 | Round state word 2 |
| x3 | input | 32 | Round state word 3 |
| rk | input | 32 | Round key |
| busy | output | 1 | Round in progress |
| done | output | 1 | One-cycle pulse when a round result is ready |
| round_out | output | XLEN | Last round result, sign-extended |

## Verification
On every cycle, the assertions check the round timing: four busy cycles, then a single-cycle done pulse. They also check that a start request cannot cut a busy run short, that the held result does not move while the sequencer is idle, and that the result's upper bits always copy bit 31. Only the bench's scenarios can show that the values are right. It checks single steps in both modes, in every byte lane, and with high selector bits set. It checks full rounds against an independent model, including a round disturbed by a start request while busy, and it compares latency across extreme data values.

// File: rtl/sm4_pkg.sv
// Shared definitions for the SM4 byte-step datapath.
// Assumes 32-bit SM4 words; the S-box is held as sixteen 128-bit rows.
package sm4_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic {
        LIN_CIPHER = 1'b0,
        LIN_KEY    = 1'b1
    } lin_mode_e;

    // Row r holds S-box outputs for inputs 16r .. 16r+15, first entry in the top byte.
    localparam logic [127:0] SBOX_ROWS [16] = '{
        128'hd690e9fecce13db716b614c228fb2c05,
        128'h2b679a762abe04c3aa44132649860699,
        128'h9c4250f491ef987a33540b43edcfac62,
        128'he4b31ca9c908e89580df94fa758f3fa6,
        128'h4707a7fcf37317ba83593c19e6854fa8,
        128'h686b81b27164da8bf8eb0f4b70569d35,
        128'h1e240e5e6358d1a225227c3b01217887,
        128'hd40046579fd327524c3602e7a0c4c89e,
        128'heabf8ad240c738b5a3f7f2cef96115a1,
        128'he0ae5da49b341a55ad933230f58cb1e3,
        128'h1df6e22e8266ca60c02923ab0d534e6f,
        128'hd5db3745defd8e2f03ff6a726d6c5b51,
        128'h8d1baf92bbddbc7f11d95c411f105ad8,
        128'h0ac13188a5cd7bbd2d74d012b8e5b4b0,
        128'h8969974a0c96777e65b9f109c56ec684,
        128'h18f07dec3adc4d2079ee5f3ed7cb3948
    };

    // Fixed-distance left rotation of a 32-bit word.
    function automatic logic [WORD_W-1:0] rol_const(input logic [WORD_W-1:0] v,
                                                    input int unsigned k);
        return (v << k) | (v >> (WORD_W - k));
    endfunction

endpackage

// File: rtl/sm4_sbox.sv
// SM4 substitution box: one byte in, one byte out, purely combinational.
// Assumes the row table in sm4_pkg; the lookup is a fixed mux tree.
module sm4_sbox
    import sm4_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);

    logic [127:0] row;
    logic [6:0]   lane_lo;

    // Pick the row by the high nibble and the byte lane by the low nibble.
    always_comb begin
        row     = SBOX_ROWS[din[7:4]];
        lane_lo = {~din[3:0], 3'b000};
        dout    = row[lane_lo +: BYTE_W];
    end

endmodule

// File: rtl/sm4_linear.sv
// Linear diffusion layer applied to a zero-extended substituted byte.
// Mode selects between the cipher layer and the key-schedule layer.
module sm4_linear
    import sm4_pkg::*;
(
    input  logic [BYTE_W-1:0] sub_byte,
    input  lin_mode_e         mode,
    output logic [WORD_W-1:0] mixed
);

    logic [WORD_W-1:0] wide;
    logic [WORD_W-1:0] cipher_mix;
    logic [WORD_W-1:0] key_mix;

    // Form both candidate layers and select one; both are always evaluated.
    always_comb begin
        wide       = {{(WORD_W-BYTE_W){1'b0}}, sub_byte};
        cipher_mix = wide ^ rol_const(wide, 2) ^ rol_const(wide, 10)
                   ^ rol_const(wide, 18) ^ rol_const(wide, 24);
        key_mix    = wide ^ rol_const(wide, 13) ^ rol_const(wide, 23);
        mixed      = (mode == LIN_KEY) ? key_mix : cipher_mix;
    end

endmodule

// File: rtl/sm4_byte_step.sv
// One byte-step: select a byte of a, substitute, mix, rotate into the
// selected lane and XOR with accumulator x. Combinational, constant depth.
module sm4_byte_step
    import sm4_pkg::*;
(
    input  logic [WORD_W-1:0] acc_in,
    input  logic [WORD_W-1:0] src,
    input  logic [1:0]        lane,
    input  lin_mode_e         mode,
    output logic [WORD_W-1:0] acc_out
);

    logic [BYTE_W-1:0] picked;
    logic [BYTE_W-1:0] subbed;
    logic [WORD_W-1:0] mixed;
    logic [WORD_W-1:0] placed;
    logic [5:0]        rot_amt;

    // Extract the byte named by the lane selector.
    always_comb picked = src[{lane, 3'b000} +: BYTE_W];

    sm4_sbox u_sbox (
        .din  (picked),
        .dout (subbed)
    );

    sm4_linear u_lin (
        .sub_byte (subbed),
        .mode     (mode),
        .mixed    (mixed)
    );

    // Rotate the mixed word left by eight times the lane and fold into the accumulator.
    always_comb begin
        rot_amt = {1'b0, lane, 3'b000};
        placed  = (mixed << rot_amt) | (mixed >> (6'd32 - rot_amt));
        acc_out = placed ^ acc_in;
    end

endmodule

// File: rtl/sm4_round_seq.sv
// Round sequencer: accepts a start while idle, forms a = x1^x2^x3^rk and
// runs four byte-steps (lanes 0..3) over four cycles, then pulses done.
// Assumes start is ignored while busy; latency is fixed at four cycles.
module sm4_round_seq
    import sm4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_in,
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic [WORD_W-1:0] w2,
    input  logic [WORD_W-1:0] w3,
    input  logic [WORD_W-1:0] key,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] result
);

    localparam int STEPS = 4;
    localparam logic [1:0] LAST = 2'(STEPS - 1);

    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] src_q;
    logic [1:0]        lane_q;
    lin_mode_e         mode_q;
    logic [WORD_W-1:0] acc_next;

    sm4_byte_step u_step (
        .acc_in  (acc_q),
        .src     (src_q),
        .lane    (lane_q),
        .mode    (mode_q),
        .acc_out (acc_next)
    );

    // Accept a round, advance one lane per cycle, publish the result on the last lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            acc_q  <= '0;
            src_q  <= '0;
            lane_q <= '0;
            mode_q <= LIN_CIPHER;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                busy   <= 1'b1;
                acc_q  <= w0;
                src_q  <= w1 ^ w2 ^ w3 ^ key;
                lane_q <= '0;
                mode_q <= lin_mode_e'(mode_in);
            end else if (busy) begin
                acc_q  <= acc_next;
                lane_q <= lane_q + 2'd1;
                if (lane_q == LAST) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    result <= acc_next;
                end
            end
        end
    end

endmodule

// File: rtl/sm4_round_unit.sv
// Top level: a combinational single byte-step path and a four-cycle round
// sequencer, both producing results sign-extended to XLEN.
// Assumes XLEN >= 32 and SEL_W >= 2; selector bits above [1:0] are ignored.
module sm4_round_unit
    import sm4_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int SEL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       step_x,
    input  logic [31:0]       step_a,
    input  logic [SEL_W-1:0]  step_sel,
    input  logic              step_mode,
    output logic [XLEN-1:0]   step_y,
    input  logic              start,
    input  logic              round_mode,
    input  logic [31:0]       x0,
    input  logic [31:0]       x1,
    input  logic [31:0]       x2,
    input  logic [31:0]       x3,
    input  logic [31:0]       rk,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   round_out
);

    localparam int EXT_W = XLEN - WORD_W;

    logic [WORD_W-1:0] step_word;
    logic [WORD_W-1:0] round_word;
    logic [SEL_W-3:0]  sel_unused;

    // Upper selector bits are deliberately not used.
    always_comb sel_unused = step_sel[SEL_W-1:2];

    sm4_byte_step u_direct (
        .acc_in  (step_x),
        .src     (step_a),
        .lane    (step_sel[1:0]),
        .mode    (lin_mode_e'(step_mode)),
        .acc_out (step_word)
    );

    sm4_round_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode_in (round_mode),
        .w0      (x0),
        .w1      (x1),
        .w2      (x2),
        .w3      (x3),
        .key     (rk),
        .busy    (busy),
        .done    (done),
        .result  (round_word)
    );

    generate
        if (EXT_W > 0) begin : g_ext
            // Replicate bit 31 into the upper register bits.
            always_comb begin
                step_y    = {{EXT_W{step_word[WORD_W-1]}}, step_word};
                round_out = {{EXT_W{round_word[WORD_W-1]}}, round_word};
            end
        end else begin : g_narrow
            // Register width equals word width: pass through.
            always_comb begin
                step_y    = step_word;
                round_out = round_word;
            end
        end
    endgenerate

endmodule

// File: rtl/sm4_round_unit_chk.sv
// Protocol checker for sm4_round_unit, bound to every instance.
// Counts busy cycles to check the fixed four-cycle round window.
module sm4_round_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] round_out
);

    logic [2:0] busy_run;

    // Length of the current busy run, cleared whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 3'd1;
        else           busy_run <= '0;
    end

    AST_BUSY_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_run < 3'd3) |=> busy);                          // R9
    AST_DONE_AFTER_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_run == 3'd3) |=> (done && !busy));              // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                              // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(round_out));                                // R10
    AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(round_out[XLEN-1:31]) == 0) ||
        ($countones(round_out[XLEN-1:31]) == XLEN - 31));             // R7

endmodule

bind sm4_round_unit sm4_round_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .round_out (round_out)
);

// File: tb/sm4_round_unit_tb_top.sv
`timescale 1ns/1ps
// Directed bench for sm4_round_unit: one task per scenario, each checking
// its own results against an independent behavioural model.
module sm4_round_unit_tb_top;

    localparam int XLEN  = 64;
    localparam int SEL_W = 5;

    localparam logic [127:0] TB_SBOX [16] = '{
        128'hd690e9fecce13db716b614c228fb2c05,
        128'h2b679a762abe04c3aa44132649860699,
        128'h9c4250f491ef987a33540b43edcfac62,
        128'he4b31ca9c908e89580df94fa758f3fa6,
        128'h4707a7fcf37317ba83593c19e6854fa8,
        128'h686b81b27164da8bf8eb0f4b70569d35,
        128'h1e240e5e6358d1a225227c3b01217887,
        128'hd40046579fd327524c3602e7a0c4c89e,
        128'heabf8ad240c738b5a3f7f2cef96115a1,
        128'he0ae5da49b341a55ad933230f58cb1e3,
        128'h1df6e22e8266ca60c02923ab0d534e6f,
        128'hd5db3745defd8e2f03ff6a726d6c5b51,
        128'h8d1baf92bbddbc7f11d95c411f105ad8,
        128'h0ac13188a5cd7bbd2d74d012b8e5b4b0,
        128'h8969974a0c96777e65b9f109c56ec684,
        128'h18f07dec3adc4d2079ee5f3ed7cb3948
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      step_x = '0;
    logic [31:0]      step_a = '0;
    logic [SEL_W-1:0] step_sel = '0;
    logic             step_mode = 1'b0;
    logic [XLEN-1:0]  step_y;
    logic             start = 1'b0;
    logic             round_mode = 1'b0;
    logic [31:0]      x0 = '0, x1 = '0, x2 = '0, x3 = '0, rk = '0;
    logic             busy;
    logic             done;
    logic [XLEN-1:0]  round_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sm4_round_unit #(.XLEN(XLEN), .SEL_W(SEL_W)) dut_i (.*);

    // ---------------- model ----------------
    function automatic logic [7:0] m_sbox(input logic [7:0] b);
        logic [127:0] r;
        r = TB_SBOX[b[7:4]];
        return r[(15 - int'(b[3:0])) * 8 +: 8];
    endfunction

    function automatic logic [31:0] m_rol(input logic [31:0] v, input int k);
        if (k == 0) return v;
        return (v << k) | (v >> (32 - k));
    endfunction

    function automatic logic [31:0] m_step(input logic [31:0] x, input logic [31:0] a,
                                           input int sel, input logic mode);
        logic [31:0] s, c;
        s = {24'h0, m_sbox(a[sel*8 +: 8])};
        if (mode) c = s ^ m_rol(s, 13) ^ m_rol(s, 23);
        else      c = s ^ m_rol(s, 2) ^ m_rol(s, 10) ^ m_rol(s, 18) ^ m_rol(s, 24);
        return m_rol(c, 8 * sel) ^ x;
    endfunction

    function automatic logic [31:0] m_round(input logic [31:0] a0, input logic [31:0] a1,
                                            input logic [31:0] a2, input logic [31:0] a3,
                                            input logic [31:0] k, input logic mode);
        logic [31:0] acc, a;
        a = a1 ^ a2 ^ a3 ^ k;
        acc = a0;
        for (int i = 0; i < 4; i++) acc = m_step(acc, a, i, mode);
        return acc;
    endfunction

    function automatic logic [XLEN-1:0] m_sext(input logic [31:0] v);
        return {{(XLEN-32){v[31]}}, v};
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset busy", XLEN'(busy), '0);
        check("R10 reset done", XLEN'(done), '0);
        check("R10 reset round_out", round_out, '0);
    endtask

    task automatic t_step_lanes;
        logic [31:0] av [3] = '{32'h0123_4567, 32'hfedc_ba98, 32'h8000_00ff};
        foreach (av[i]) begin
            for (int m = 0; m < 2; m++) begin
                for (int s = 0; s < 4; s++) begin
                    @(negedge clk);
                    step_x = 32'h1357_9bdf ^ av[i];
                    step_a = av[i];
                    step_sel = SEL_W'(s);
                    step_mode = m[0];
                    #1;
                    check(m ? "R4 R5 R2 R1 step key layer" : "R3 R5 R2 R1 step cipher layer",
                          step_y, m_sext(m_step(step_x, step_a, s, m[0])));
                end
            end
        end
    endtask

    task automatic t_sel_upper;
        logic [XLEN-1:0] ref_y;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            step_x = 32'hdead_beef;
            step_a = 32'h5a3c_96e1;
            step_mode = 1'b0;
            step_sel = SEL_W'(s);
            #1;
            ref_y = step_y;
            step_sel = {3'b101, 2'(s)};
            #1;
            check("R1 upper selector bits ignored", step_y, ref_y);
            check("R1 lane value", step_y, m_sext(m_step(32'hdead_beef, 32'h5a3c_96e1, s, 1'b0)));
        end
    endtask

    task automatic t_step_sign;
        @(negedge clk);
        step_x = 32'h8000_0000; step_a = 32'h0; step_sel = '0; step_mode = 1'b0;
        #1;
        check("R7 step sign extension", step_y, m_sext(m_step(32'h8000_0000, 32'h0, 0, 1'b0)));
        step_x = 32'h7fff_ffff;
        #1;
        check("R7 step sign extension clear", step_y, m_sext(m_step(32'h7fff_ffff, 32'h0, 0, 1'b0)));
    endtask

    // Run one round and check timing and result; optional start pulse while busy.
    task automatic run_round(input logic [31:0] a0, input logic [31:0] a1,
                             input logic [31:0] a2, input logic [31:0] a3,
                             input logic [31:0] k, input logic mode, input bit poke);
        logic [XLEN-1:0] exp;
        exp = m_sext(m_round(a0, a1, a2, a3, k, mode));
        @(negedge clk);
        x0 = a0; x1 = a1; x2 = a2; x3 = a3; rk = k; round_mode = mode; start = 1'b1;
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            if (c == 1 && !poke) start = 1'b0;
            if (poke) begin
                x0 = ~a0; x1 = a1 + 32'd7; rk = ~k; round_mode = ~mode; start = (c < 4);
            end
            check("R8 R11 busy during round", XLEN'({busy, done}), XLEN'(2'b10));
        end
        start = 1'b0;
        @(negedge clk);
        check("R8 R11 done pulse", XLEN'({busy, done}), XLEN'(2'b01));
        check(poke ? "R9 round result with start while busy" : "R6 R7 round result",
              round_out, exp);
        @(negedge clk);
        check("R8 done single cycle", XLEN'(done), '0);
        check("R10 result held", round_out, exp);
    endtask

    task automatic t_rounds;
        run_round(32'h0123_4567, 32'h89ab_cdef, 32'hfedc_ba98, 32'h7654_3210,
                  32'hf121_86f9, 1'b0, 1'b0);
        run_round(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
                  32'h0000_0000, 1'b0, 1'b0);
        run_round(32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff,
                  32'hffff_ffff, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++)
            run_round($urandom, $urandom, $urandom, $urandom, $urandom, i[0], 1'b0);
    endtask

    task automatic t_busy_ignore;
        run_round(32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888,
                  32'h9999_aaaa, 1'b0, 1'b1);
        run_round(32'hcafe_f00d, 32'h0bad_c0de, 32'h1234_5678, 32'h9abc_def0,
                  32'h0f0f_0f0f, 1'b1, 1'b1);
    endtask

    task automatic t_idle_hold;
        logic [XLEN-1:0] held;
        held = round_out;
        @(negedge clk);
        x0 = 32'hffff_0000; x1 = 32'h1; rk = 32'h2; round_mode = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 idle output unchanged by inputs", round_out, held);
        check("R8 no done while idle", XLEN'({busy, done}), '0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_step_lanes();
        t_sel_upper();
        t_step_sign();
        t_rounds();
        t_busy_ignore();
        t_idle_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule